// File: doc/BRIEF.md
# Triggered DAC Data Front End

This block is the digital register front end of one 12-bit digital-to-analog converter channel. Software writes a conversion value into a holding register through one of three formatted windows: 12 bits right-justified, 12 bits left-justified, or 8 bits that land in the upper bits of the code. The block then copies the held value into a read-only output register, and that register drives the 12-bit code to the analog converter. The analog level is linear in the code, and code 4095 is full scale.

The copy happens in one of two ways. In free mode it follows a write automatically. In trigger mode it waits for a selected event: a rising edge on an external line, a rising edge on one of four timer trigger lines, or a software trigger bit. Hardware events can also raise a DMA request. If another hardware event arrives while that request is still unacknowledged, the block records an underrun, and the underrun can drive an interrupt. The block's only outputs towards the analog side are the code and an output-buffer enable.

Top module: `dac_front`

## Requirements
- R1: After reset the code, the control register, the status register, the DMA request and the interrupt are all zero, and the buffer enable is 1.
- R2: A write to offset 0x08 loads bits 11:0 of the write data into the holding register, and bits 15:12 are ignored. With the channel enabled (control bit 0) and trigger mode off (control bit 2 = 0), the code takes the held value within two clocks. Offset 0x2C reads the code back in bits 11:0.
- R3: A write to offset 0x0C loads bits 15:4 of the write data into the holding register, and bits 3:0 are ignored.
- R4: A write to offset 0x10 loads bits 7:0 of the write data into bits 11:4 of the holding register and clears bits 3:0.
- R5: A read of 0x08 returns the held value in bits 11:0. A read of 0x0C returns it in bits 15:4. A read of 0x10 returns held bits 11:4 in bits 7:0.
- R6: While the channel is disabled, the code never changes, whatever is written.
- R7: In trigger mode the code changes only on a rising edge of the source chosen by control bits 5:3. Code 0 selects the external line, and codes 1 to 4 select timer lines 0 to 3. Writes and edges on other lines leave the code unchanged.
- R8: Select code 7 picks the software trigger. Writing 1 to bit 0 of offset 0x04 copies the held value to the code, and that bit then reads 0.
- R9: While the channel is enabled, writes to control bits 5:3 are ignored. Writes to the other control fields still take effect.
- R10: With control bit 12 set, a selected hardware edge raises the DMA request, and the request stays high until the acknowledge input is seen. A software trigger never raises the request.
- R11: A selected hardware edge that arrives while the request is still high and not acknowledged sets status bit 0 (offset 0x30). Writing 1 to that bit clears it.
- R12: The interrupt equals status bit 0 AND control bit 13. The buffer enable output is the inverse of control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| ext_trig | input | 1 | External trigger line, asynchronous |
| tmr_trig | input | 4 | Timer trigger lines, asynchronous |
| dma_ack | input | 1 | DMA acknowledge |
| dma_req | output | 1 | DMA request |
| udr_irq | output | 1 | Underrun interrupt |
| dac_code | output | 12 | Code driven to the converter |
| dac_buf_en | output | 1 | Output buffer enable |

## Verification
The hardest situation to reach is the underrun. It needs trigger mode, the channel enabled, DMA enabled and a timer line selected. The stimulus then sends two synchronized edges on that line with the acknowledge held low between them, and checks the flag and the interrupt before and after the write-1 clear. The trigger sweep walks every select code from 0 to 4 against every line. For each pair it sees whether the code moved, so only the matching line counts as a hit. A second pass then sends one edge and one acknowledge at a time, and checks that no flag appears.

// File: rtl/dac_front.sv
module dac_front #(
  parameter int ADDR_W  = 6,
  parameter int BUS_W   = 16,
  parameter int CODE_W  = 12,
  parameter int NUM_TMR = 4,
  parameter int SEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ext_trig,
  input  logic [NUM_TMR-1:0] tmr_trig,
  input  logic              dma_ack,
  output logic              dma_req,
  output logic              udr_irq,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_buf_en
);

  localparam int NLINE  = NUM_TMR + 1;
  localparam int NSEL   = 2 ** SEL_W;
  localparam int LSH    = BUS_W - CODE_W;
  localparam int BYTE_W = CODE_W - LSH;
  localparam logic [SEL_W-1:0] SEL_SW = '1;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] A_SWT  = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] A_R12  = ADDR_W'(6'h08);
  localparam logic [ADDR_W-1:0] A_L12  = ADDR_W'(6'h0C);
  localparam logic [ADDR_W-1:0] A_R8   = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(6'h2C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(6'h30);

  localparam int B_EN = 0, B_BOFF = 1, B_TEN = 2, B_SEL = 3, B_DMA = 12, B_UIE = 13;

  logic              chan_en, buf_off, trig_en, dma_en, udr_ie;
  logic [SEL_W-1:0]  trig_sel;
  logic              sw_bit, load_pend, udr_flag, dma_req_q;
  logic [CODE_W-1:0] hold, out_code;
  logic [NLINE-1:0]  s1, s2, s3;

  wire w_ctrl = bus_wr && bus_addr == A_CTRL;
  wire w_swt  = bus_wr && bus_addr == A_SWT;
  wire w_r12  = bus_wr && bus_addr == A_R12;
  wire w_l12  = bus_wr && bus_addr == A_L12;
  wire w_r8   = bus_wr && bus_addr == A_R8;
  wire w_stat = bus_wr && bus_addr == A_STAT;

  wire [NLINE-1:0] hw_rise = s2 & ~s3;
  wire [NSEL-1:0]  rise_x  = NSEL'(hw_rise);
  wire active  = chan_en & trig_en;
  wire hw_fire = active & rise_x[trig_sel];
  wire sw_fire = active & sw_bit & (trig_sel == SEL_SW);
  wire xfer    = (chan_en & ~trig_en & load_pend) | hw_fire | sw_fire;
  wire dma_fire = hw_fire & dma_en;
  wire udr_set  = dma_fire & dma_req_q & ~dma_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= {tmr_trig, ext_trig};
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en  <= 1'b0;
      buf_off  <= 1'b0;
      trig_en  <= 1'b0;
      trig_sel <= '0;
      dma_en   <= 1'b0;
      udr_ie   <= 1'b0;
    end else if (w_ctrl) begin
      chan_en <= bus_wdata[B_EN];
      buf_off <= bus_wdata[B_BOFF];
      trig_en <= bus_wdata[B_TEN];
      dma_en  <= bus_wdata[B_DMA];
      udr_ie  <= bus_wdata[B_UIE];
      if (!chan_en) trig_sel <= bus_wdata[B_SEL +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      load_pend <= 1'b0;
    end else begin
      load_pend <= w_r12 | w_l12 | w_r8;
      if (w_r12)     hold <= bus_wdata[CODE_W-1:0];
      else if (w_l12) hold <= bus_wdata[BUS_W-1:LSH];
      else if (w_r8)  hold <= {bus_wdata[BYTE_W-1:0], {LSH{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_code <= '0;
    else if (xfer) out_code <= hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_bit <= 1'b0;
    else if (sw_fire) sw_bit <= 1'b0;
    else if (w_swt && bus_wdata[0]) sw_bit <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_req_q <= 1'b0;
      udr_flag  <= 1'b0;
    end else begin
      dma_req_q <= dma_fire | (dma_req_q & ~dma_ack);
      if (udr_set) udr_flag <= 1'b1;
      else if (w_stat && bus_wdata[0]) udr_flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_EN]            = chan_en;
        bus_rdata[B_BOFF]          = buf_off;
        bus_rdata[B_TEN]           = trig_en;
        bus_rdata[B_SEL +: SEL_W]  = trig_sel;
        bus_rdata[B_DMA]           = dma_en;
        bus_rdata[B_UIE]           = udr_ie;
      end
      A_SWT:  bus_rdata[0] = sw_bit;
      A_R12:  bus_rdata[CODE_W-1:0] = hold;
      A_L12:  bus_rdata[BUS_W-1:LSH] = hold;
      A_R8:   bus_rdata[BYTE_W-1:0] = hold[CODE_W-1:LSH];
      A_OUT:  bus_rdata[CODE_W-1:0] = out_code;
      A_STAT: bus_rdata[0] = udr_flag;
      default: bus_rdata = '0;
    endcase
  end

  assign dma_req    = dma_req_q;
  assign udr_irq    = udr_flag & udr_ie;
  assign dac_code   = out_code;
  assign dac_buf_en = ~buf_off;

endmodule

module dac_front_chk #(
  parameter int CODE_W = 12,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              hw_fire,
  input logic              udr_flag,
  input logic              chan_en,
  input logic [SEL_W-1:0]  trig_sel,
  input logic [CODE_W-1:0] dac_code
);

  // R10
  req_drop_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_req) |-> $past(dma_ack));

  // R10
  req_from_hw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(hw_fire));

  // R11
  udr_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udr_flag) |-> $past(dma_req));

  // R9
  sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && $past(chan_en)) |-> $stable(trig_sel));

  // R6
  code_frozen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(chan_en) |-> $stable(dac_code));

endmodule

bind dac_front dac_front_chk #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_ack(dma_ack),
  .hw_fire(hw_fire), .udr_flag(udr_flag), .chan_en(chan_en),
  .trig_sel(trig_sel), .dac_code(dac_code)
);

// File: tb/test_dac_front.sv
module test_dac_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [4:0]  lines = '0;
  logic        dma_ack = 1'b0;
  logic        dma_req, udr_irq, dac_buf_en;
  logic [11:0] dac_code;

  int total = 0, bad = 0;
  bit done = 0;
  logic [11:0] exp_code;

  always #2 clk = ~clk;

  dac_front i_dac_front (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(lines[0]),
    .tmr_trig(lines[4:1]), .dma_ack(dma_ack), .dma_req(dma_req),
    .udr_irq(udr_irq), .dac_code(dac_code), .dac_buf_en(dac_buf_en)
  );

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int ln);
    @(negedge clk);
    lines[ln] = 1'b1;
    @(negedge clk);
    lines[ln] = 1'b0;
    idle(5);
  endtask

  task automatic ack;
    @(negedge clk);
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(dac_code, 0, "R1");
    chk(dma_req, 0, "R1");
    chk(udr_irq, 0, "R1");
    chk(dac_buf_en, 1, "R1");
    rd(6'h00, v); chk(v, 0, "R1");
    rd(6'h30, v); chk(v, 0, "R1");

    // R6 disabled channel: writes never reach the code
    wr(6'h08, 16'h0ABC); idle(3);
    chk(dac_code, 0, "R6");
    rd(6'h2C, v); chk(v, 0, "R6");
    wr(6'h00, 16'h0001); idle(3);
    chk(dac_code, 0, "R6");

    // R2 sweep 12-bit right view, top nibble is garbage
    for (int x = 0; x < 4096; x += 37) begin
      wr(6'h08, 16'hF000 | 16'(x)); idle(2);
      chk(dac_code, x, "R2");
      rd(6'h2C, v); chk(v, x, "R2");
      // R5 views
      rd(6'h08, v); chk(v, x, "R5");
      rd(6'h0C, v); chk(v, x << 4, "R5");
      rd(6'h10, v); chk(v, x >> 4, "R5");
    end
    wr(6'h08, 16'h0FFF); idle(2); chk(dac_code, 4095, "R2");

    // R3 12-bit left view, low nibble garbage
    for (int x = 0; x < 4096; x += 53) begin
      wr(6'h0C, 16'(x << 4) | 16'h000F); idle(2);
      chk(dac_code, x, "R3");
    end

    // R4 every byte through the 8-bit view
    for (int b = 0; b < 256; b++) begin
      wr(6'h10, 16'hFF00 | 16'(b)); idle(2);
      chk(dac_code, b << 4, "R4");
      rd(6'h10, v); chk(v, b, "R4");
    end
    exp_code = 12'hFF0;

    // R12 buffer enable
    wr(6'h00, 16'h0003); idle(1); chk(dac_buf_en, 0, "R12");
    wr(6'h00, 16'h0001); idle(1); chk(dac_buf_en, 1, "R12");

    // R9 select locked while enabled
    wr(6'h00, 16'h0000);
    wr(6'h00, 16'h0011);
    wr(6'h00, 16'h0029); rd(6'h00, v); chk(v, 16'h0011, "R9");
    wr(6'h00, 16'h0030); rd(6'h00, v); chk(v, 16'h0010, "R9");
    wr(6'h00, 16'h0030); rd(6'h00, v); chk(v, 16'h0030, "R9");

    // R7 select vs every hardware line
    for (int s = 0; s < 5; s++) begin
      wr(6'h00, 16'h0000);
      wr(6'h00, 16'(5 | (s << 3)));
      for (int ln = 0; ln < 5; ln++) begin
        logic [11:0] nv;
        nv = 12'(100 + s * 37 + ln * 5);
        wr(6'h08, 16'(nv)); idle(3);
        chk(dac_code, exp_code, "R7");
        pulse(ln);
        if (ln == s) exp_code = nv;
        chk(dac_code, exp_code, "R7");
      end
    end

    // R8 software trigger
    wr(6'h00, 16'h0000);
    wr(6'h00, 16'h103D);
    wr(6'h08, 16'h0321); idle(3);
    chk(dac_code, exp_code, "R8");
    wr(6'h04, 16'h0001); idle(3);
    chk(dac_code, 12'h321, "R8");
    rd(6'h04, v); chk(v, 0, "R8");
    // R10 software trigger never requests DMA
    chk(dma_req, 0, "R10");
    exp_code = 12'h321;

    // R10 and R11 with timer line 0, DMA and interrupt enabled
    wr(6'h00, 16'h0000);
    wr(6'h00, 16'h300D);
    pulse(1);
    chk(dma_req, 1, "R10");
    idle(4); chk(dma_req, 1, "R10");
    ack; idle(1); chk(dma_req, 0, "R10");
    for (int k = 0; k < 4; k++) begin
      pulse(1); chk(dma_req, 1, "R10");
      ack; idle(1); chk(dma_req, 0, "R10");
    end
    rd(6'h30, v); chk(v, 0, "R11");
    pulse(1); pulse(1);
    rd(6'h30, v); chk(v, 1, "R11");
    chk(udr_irq, 1, "R12");
    wr(6'h30, 16'h0001); idle(1);
    rd(6'h30, v); chk(v, 0, "R11");
    chk(udr_irq, 0, "R12");
    ack; idle(1);
    // R12 flag without enable gives no interrupt
    wr(6'h00, 16'h100D);
    pulse(1); pulse(1);
    rd(6'h30, v); chk(v, 1, "R11");
    chk(udr_irq, 0, "R12");
    wr(6'h00, 16'h300D); idle(1);
    chk(udr_irq, 1, "R12");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule